// File: doc/BRIEF.md
# Latency-Hiding Warp Scheduler

This block picks one warp per clock from a pool of resident warps and presents it on a single issue slot. A warp can be picked when three things are true: it is resident, it reports an instruction ready, and it is not waiting on a long-latency memory read. Changing from one warp to another costs no cycles. A warp that stalls on memory therefore drops out of the candidate set, and the slot stays busy with the other warps until the stalled warp's data comes back.

Each outstanding load has its own down-counter per warp. The counter starts from a latency register that can be written, so that memory round trips of several hundred cycles can be modelled. A warp also becomes eligible again as soon as an explicit return notice arrives for it. Warps are launched and retired by ID. The block shows the number of resident warps on an occupancy output, and it counts the cycles in which no warp could issue.

Top module: `warp_sched_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, no warp is resident, occupancy reads 0, issue_valid is 0 (even with every ready_in bit set) and stall_count is 0.
- R2: A warp is eligible when it is resident, its ready_in bit is 1 and it has no wait pending. issue_valid is 1 in the same cycle whenever at least one warp is eligible, and in that case issue_id names an eligible warp.
- R3: The choice is round-robin. It takes the lowest-numbered eligible warp strictly above the warp issued last. If there is none above, it wraps to the lowest-numbered eligible warp. After reset the search starts at warp 0.
- R4: A launch makes the warp resident, and a retire removes it. Both take effect at the next clock edge, and occupancy follows the number of resident warps. Launching a warp that is already resident, or retiring one that is not, changes nothing. A launch and a retire of the same ID in the same cycle leave the warp resident.
- R5: A memory request for a warp, made while the latency register holds L ≥ 1, makes the warp ineligible for exactly the L cycles that follow the request's clock edge. The latency register takes a new value on the edge where cfg_lat_we is 1. A request made while L = 0 has no effect.
- R6: A memory return for a waiting warp makes it eligible from the next cycle. If a request and a return for the same warp come in the same cycle, the request wins.
- R7: stall_count goes up by one on each clock edge that ends a cycle with issue_valid at 0. It stops at its maximum value.
- R8: Warp IDs run from 0 to NUM_WARPS-1 (64 by default), and warp NUM_WARPS-1 takes part in the wrap-around of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch the warp named by launch_id |
| launch_id | input | 6 | ID of the warp to launch |
| retire_valid | input | 1 | Retire the warp named by retire_id |
| retire_id | input | 6 | ID of the warp to retire |
| ready_in | input | NUM_WARPS | Per-warp flag: instruction ready to issue |
| mem_req_valid | input | 1 | A long-latency read was issued for mem_req_id |
| mem_req_id | input | 6 | Warp that issued the read |
| mem_ret_valid | input | 1 | Data has returned for mem_ret_id |
| mem_ret_id | input | 6 | Warp whose data has returned |
| cfg_lat_we | input | 1 | Write enable for the latency register |
| cfg_lat | input | LAT_W | New return latency in cycles |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_id | output | 6 | ID of the issued warp |
| occupancy | output | 7 | Number of resident warps |
| stall_count | output | STALL_W | Saturating count of cycles with no issue |

## Verification
issue_valid and issue_id depend combinationally on ready_in and on registered state. The bench changes ready_in on a falling edge and reads the selection 1 ns later, in the same cycle. Launch, retire, return and latency writes take effect at the next rising edge, so their results are checked at the falling edge that follows. A request at latency L is checked as L falling edges with the warp blocked and then one with it issued, which matches the L cycles after the request edge. stall_count is registered and lags issue_valid by one edge. Its checks take the difference between two samples taken one falling edge after the cycles being counted.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    localparam int MAX_WARPS = 64;
    localparam int ID_W      = $clog2(MAX_WARPS);

    typedef logic [ID_W-1:0]      warp_id_t;
    typedef logic [MAX_WARPS-1:0] warp_vec_t;

    typedef struct packed {
        logic     valid;
        warp_id_t id;
    } warp_evt_t;

    // Lowest set bit of a vector; returns 0 if none is set.
    function automatic warp_id_t first_set(input warp_vec_t v);
        warp_id_t r;
        r = '0;
        for (int i = MAX_WARPS - 1; i >= 0; i--) begin
            if (v[i]) r = warp_id_t'(i);
        end
        return r;
    endfunction

    // One-hot decode of an event.
    function automatic warp_vec_t evt_onehot(input warp_evt_t e);
        warp_vec_t r;
        r = '0;
        if (e.valid) r[e.id] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/warp_residency.sv
module warp_residency import warp_sched_pkg::*; #(
    parameter int NUM_WARPS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  warp_evt_t            launch,
    input  warp_evt_t            retire,
    output logic [NUM_WARPS-1:0] resident,
    output logic [NUM_WARPS-1:0] clear_vec,
    output logic [ID_W:0]        occupancy
);
    localparam int OCC_W = ID_W + 1;

    logic [NUM_WARPS-1:0] res_q;
    logic [OCC_W-1:0]     occ_q;
    logic                 grow;
    logic                 shrink;
    warp_vec_t            launch_oh;
    warp_vec_t            retire_oh;

    always_comb begin
        launch_oh = evt_onehot(launch);
        retire_oh = evt_onehot(retire);
        grow      = launch.valid && !res_q[launch.id];
        shrink    = retire.valid && res_q[retire.id] &&
                    !(launch.valid && launch.id == retire.id);
        clear_vec = launch_oh[NUM_WARPS-1:0] | retire_oh[NUM_WARPS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            occ_q <= '0;
        end else begin
            // launch of the same id takes precedence over retire
            res_q <= (res_q & ~retire_oh[NUM_WARPS-1:0]) | launch_oh[NUM_WARPS-1:0];
            occ_q <= occ_q + OCC_W'(grow) - OCC_W'(shrink);
        end
    end

    assign resident  = res_q;
    assign occupancy = occ_q;

    // R4: the occupancy counter tracks the resident set
    p_occ_match_r4: assert property (@(posedge clk) disable iff (rst)
        int'(occ_q) == $countones(res_q));

    // R4: a launched warp is resident on the next cycle
    p_launch_sticks_r4: assert property (@(posedge clk) disable iff (rst)
        launch.valid |=> res_q[$past(launch.id)]);

endmodule

// File: rtl/warp_latency_track.sv
module warp_latency_track import warp_sched_pkg::*; #(
    parameter int NUM_WARPS = 64,
    parameter int LAT_W     = 10,
    parameter int DEF_LAT   = 400
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [LAT_W-1:0]     cfg_lat,
    input  warp_evt_t            req,
    input  warp_evt_t            ret,
    input  logic [NUM_WARPS-1:0] clear_vec,
    output logic [NUM_WARPS-1:0] waiting
);
    logic [LAT_W-1:0]     lat_q;
    logic [NUM_WARPS-1:0] wait_q;
    logic [NUM_WARPS-1:0] req_hit;
    logic [NUM_WARPS-1:0] ret_hit;
    logic [LAT_W-1:0]     cnt_q [NUM_WARPS];
    warp_vec_t            req_oh;
    warp_vec_t            ret_oh;

    always_ff @(posedge clk) begin
        if (rst)         lat_q <= LAT_W'(DEF_LAT);
        else if (cfg_we) lat_q <= cfg_lat;
    end

    always_comb begin
        req_oh  = evt_onehot(req);
        ret_oh  = evt_onehot(ret);
        req_hit = (lat_q != '0) ? req_oh[NUM_WARPS-1:0] : '0;
        ret_hit = ret_oh[NUM_WARPS-1:0];
    end

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        always_ff @(posedge clk) begin
            if (rst) begin
                wait_q[g] <= 1'b0;
                cnt_q[g]  <= '0;
            end else if (clear_vec[g]) begin
                wait_q[g] <= 1'b0;
                cnt_q[g]  <= '0;
            end else if (req_hit[g]) begin
                wait_q[g] <= 1'b1;
                cnt_q[g]  <= lat_q;
            end else if (ret_hit[g]) begin
                wait_q[g] <= 1'b0;
                cnt_q[g]  <= '0;
            end else if (wait_q[g]) begin
                if (cnt_q[g] <= LAT_W'(1)) begin
                    wait_q[g] <= 1'b0;
                    cnt_q[g]  <= '0;
                end else begin
                    cnt_q[g]  <= cnt_q[g] - LAT_W'(1);
                end
            end
        end

        // R5: a waiting warp with time left stays blocked
        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (wait_q[g] && cnt_q[g] > LAT_W'(1) && !clear_vec[g] && !ret_hit[g])
            |=> wait_q[g]);

        // R6: a return with no competing request frees the warp
        p_release_r6: assert property (@(posedge clk) disable iff (rst)
            (ret_hit[g] && !req_hit[g]) |=> !wait_q[g]);
    end

    assign waiting = wait_q;

    // R5: an accepted request blocks its warp from the next cycle
    p_req_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (req.valid && lat_q != '0 && !clear_vec[req.id]) |=> wait_q[$past(req.id)]);

endmodule

// File: rtl/warp_rr_pick.sv
module warp_rr_pick import warp_sched_pkg::*; #(
    parameter int NUM_WARPS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] eligible,
    output logic                 pick_valid,
    output warp_id_t             pick_id
);
    warp_id_t             last_q;
    logic [NUM_WARPS-1:0] above;
    warp_vec_t            search;

    always_comb begin
        for (int i = 0; i < NUM_WARPS; i++) begin
            above[i] = eligible[i] && (warp_id_t'(i) > last_q);
        end
        search = '0;
        search[NUM_WARPS-1:0] = (|above) ? above : eligible;
        pick_valid = |eligible;
        pick_id    = first_set(search);
    end

    always_ff @(posedge clk) begin
        if (rst)             last_q <= warp_id_t'(NUM_WARPS - 1);
        else if (pick_valid) last_q <= pick_id;
    end

    // R3: the picked warp is always one of the candidates
    p_pick_ok_r3: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> eligible[pick_id]);

    // R3: with one candidate above the last pick, that one is chosen
    p_next_above_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(above) == 1 && pick_valid) |-> (pick_id > last_q));

endmodule

// File: rtl/warp_sched_top.sv
module warp_sched_top import warp_sched_pkg::*; #(
    parameter int NUM_WARPS = 64,
    parameter int LAT_W     = 10,
    parameter int DEF_LAT   = 400,
    parameter int STALL_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch_valid,
    input  logic [ID_W-1:0]      launch_id,
    input  logic                 retire_valid,
    input  logic [ID_W-1:0]      retire_id,
    input  logic [NUM_WARPS-1:0] ready_in,
    input  logic                 mem_req_valid,
    input  logic [ID_W-1:0]      mem_req_id,
    input  logic                 mem_ret_valid,
    input  logic [ID_W-1:0]      mem_ret_id,
    input  logic                 cfg_lat_we,
    input  logic [LAT_W-1:0]     cfg_lat,
    output logic                 issue_valid,
    output logic [ID_W-1:0]      issue_id,
    output logic [ID_W:0]        occupancy,
    output logic [STALL_W-1:0]   stall_count
);
    localparam logic [STALL_W-1:0] STALL_MAX = '1;

    warp_evt_t            launch_e, retire_e, req_e, ret_e;
    logic [NUM_WARPS-1:0] resident;
    logic [NUM_WARPS-1:0] clear_vec;
    logic [NUM_WARPS-1:0] waiting;
    logic [NUM_WARPS-1:0] eligible;
    logic [STALL_W-1:0]   stall_q;
    warp_id_t             pick_id;
    logic                 pick_valid;

    assign launch_e = '{valid: launch_valid,  id: launch_id};
    assign retire_e = '{valid: retire_valid,  id: retire_id};
    assign req_e    = '{valid: mem_req_valid, id: mem_req_id};
    assign ret_e    = '{valid: mem_ret_valid, id: mem_ret_id};

    warp_residency #(.NUM_WARPS(NUM_WARPS)) u_res (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch_e),
        .retire    (retire_e),
        .resident  (resident),
        .clear_vec (clear_vec),
        .occupancy (occupancy)
    );

    warp_latency_track #(
        .NUM_WARPS (NUM_WARPS),
        .LAT_W     (LAT_W),
        .DEF_LAT   (DEF_LAT)
    ) u_lat (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_lat_we),
        .cfg_lat   (cfg_lat),
        .req       (req_e),
        .ret       (ret_e),
        .clear_vec (clear_vec),
        .waiting   (waiting)
    );

    assign eligible = resident & ready_in & ~waiting;

    warp_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .eligible   (eligible),
        .pick_valid (pick_valid),
        .pick_id    (pick_id)
    );

    assign issue_valid = pick_valid;
    assign issue_id    = pick_id;

    always_ff @(posedge clk) begin
        if (rst)                                   stall_q <= '0;
        else if (!pick_valid && stall_q != STALL_MAX) stall_q <= stall_q + STALL_W'(1);
    end

    assign stall_count = stall_q;

    // R2: an issued warp is resident, ready and not waiting on memory
    p_issue_ok_r2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (resident[issue_id] && ready_in[issue_id] && !waiting[issue_id]));

    // R2: the slot is never idle while some resident warp can go
    p_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (|(resident & ready_in & ~waiting)) |-> issue_valid);

    // R7: an idle cycle advances the stall count until it saturates
    p_stall_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!issue_valid && stall_count != STALL_MAX) |=> stall_count == $past(stall_count) + STALL_W'(1));

    // R7: an issue cycle leaves the stall count unchanged
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> $stable(stall_count));

endmodule

// File: tb/sim_warp_sched_top.sv
`timescale 1ns/1ps
module sim_warp_sched_top;

    localparam int NW = 64;
    localparam int LW = 10;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          launch_valid = 1'b0;
    logic [5:0]    launch_id = '0;
    logic          retire_valid = 1'b0;
    logic [5:0]    retire_id = '0;
    logic [NW-1:0] ready_in = '0;
    logic          mem_req_valid = 1'b0;
    logic [5:0]    mem_req_id = '0;
    logic          mem_ret_valid = 1'b0;
    logic [5:0]    mem_ret_id = '0;
    logic          cfg_lat_we = 1'b0;
    logic [LW-1:0] cfg_lat = '0;
    logic          issue_valid;
    logic [5:0]    issue_id;
    logic [6:0]    occupancy;
    logic [SW-1:0] stall_count;

    int checks = 0;
    int errors = 0;
    logic [SW-1:0] s0;

    always #4 clk = ~clk;

    warp_sched_top #(.NUM_WARPS(NW), .LAT_W(LW), .DEF_LAT(400), .STALL_W(SW)) u0 (
        .clk(clk), .rst(rst),
        .launch_valid(launch_valid), .launch_id(launch_id),
        .retire_valid(retire_valid), .retire_id(retire_id),
        .ready_in(ready_in),
        .mem_req_valid(mem_req_valid), .mem_req_id(mem_req_id),
        .mem_ret_valid(mem_ret_valid), .mem_ret_id(mem_ret_id),
        .cfg_lat_we(cfg_lat_we), .cfg_lat(cfg_lat),
        .issue_valid(issue_valid), .issue_id(issue_id),
        .occupancy(occupancy), .stall_count(stall_count)
    );

    typedef struct packed {
        logic [63:0] rdy;
        logic        v;
        logic [5:0]  id;
    } vec_t;

    // Round-robin sequence with all 64 warps resident; pointer starts at 63.
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd1},
        '{64'h0000_0000_0000_0021, 1'b1, 6'd5},
        '{64'h0000_0000_0000_0021, 1'b1, 6'd0},
        '{64'h8000_0000_0000_0000, 1'b1, 6'd63},
        '{64'h8000_0000_0000_0000, 1'b1, 6'd63},
        '{64'h0000_0000_0000_0000, 1'b0, 6'd0},
        '{64'h0000_0100_0010_0400, 1'b1, 6'd10},
        '{64'h0000_0100_0010_0400, 1'b1, 6'd20},
        '{64'h0000_0100_0010_0400, 1'b1, 6'd40},
        '{64'h0000_0100_0010_0400, 1'b1, 6'd10},
        '{64'hFFFF_FFFF_0000_0000, 1'b1, 6'd32}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        ready_in = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 occupancy", 64'(occupancy), 0);
        chk("R1 issue_valid", 64'(issue_valid), 0);
        chk("R1 stall_count", 64'(stall_count), 0);

        ready_in = '0;
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            launch_valid = 1'b1;
            launch_id    = 6'(i);
        end
        @(negedge clk);
        launch_valid = 1'b0;
        #1;
        chk("R4 occupancy all launched", 64'(occupancy), 64);

        // R3 / R8: round-robin table, including wrap through warp 63
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            ready_in = VEC[k].rdy;
            #1;
            chk("R2 issue_valid vec", 64'(issue_valid), 64'(VEC[k].v));
            if (VEC[k].v) chk("R3 issue_id vec", 64'(issue_id), 64'(VEC[k].id));
        end

        // R5: latency 5 blocks warp 3 for exactly five cycles
        @(negedge clk);
        ready_in   = 64'h8;
        cfg_lat_we = 1'b1;
        cfg_lat    = 10'd5;
        @(negedge clk);
        cfg_lat_we    = 1'b0;
        mem_req_valid = 1'b1;
        mem_req_id    = 6'd3;
        #1;
        s0 = stall_count;
        chk("R2 issue before request", 64'(issue_valid), 1);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            mem_req_valid = 1'b0;
            #1;
            chk("R5 blocked cycle", 64'(issue_valid), 0);
        end
        @(negedge clk);
        #1;
        chk("R5 ready after latency", 64'(issue_valid), 1);
        chk("R5 issued id", 64'(issue_id), 3);
        chk("R7 stall cycles counted", 64'(stall_count), 64'(s0) + 5);

        // R5: zero latency request is ignored
        @(negedge clk);
        cfg_lat_we = 1'b1;
        cfg_lat    = 10'd0;
        @(negedge clk);
        cfg_lat_we    = 1'b0;
        mem_req_valid = 1'b1;
        @(negedge clk);
        mem_req_valid = 1'b0;
        #1;
        chk("R5 zero latency no wait", 64'(issue_valid), 1);

        // R6: return releases early; request beats return
        @(negedge clk);
        cfg_lat_we = 1'b1;
        cfg_lat    = 10'd100;
        @(negedge clk);
        cfg_lat_we    = 1'b0;
        mem_req_valid = 1'b1;
        @(negedge clk);
        mem_req_valid = 1'b0;
        #1;
        chk("R6 waiting before return", 64'(issue_valid), 0);
        mem_ret_valid = 1'b1;
        mem_ret_id    = 6'd3;
        @(negedge clk);
        mem_ret_valid = 1'b0;
        #1;
        chk("R6 ready after return", 64'(issue_valid), 1);
        mem_req_valid = 1'b1;
        mem_ret_valid = 1'b1;
        @(negedge clk);
        mem_req_valid = 1'b0;
        mem_ret_valid = 1'b0;
        #1;
        chk("R6 request wins over return", 64'(issue_valid), 0);
        mem_ret_valid = 1'b1;
        @(negedge clk);
        mem_ret_valid = 1'b0;
        #1;
        chk("R6 released again", 64'(issue_valid), 1);

        // R4: retire, double retire, launch+retire same id, relaunch
        retire_valid = 1'b1;
        retire_id    = 6'd3;
        @(negedge clk);
        #1;
        chk("R4 occupancy after retire", 64'(occupancy), 63);
        chk("R4 retired warp not issued", 64'(issue_valid), 0);
        @(negedge clk);
        retire_valid = 1'b0;
        #1;
        chk("R4 retire of absent warp", 64'(occupancy), 63);
        launch_valid = 1'b1;
        launch_id    = 6'd3;
        retire_valid = 1'b1;
        @(negedge clk);
        retire_valid = 1'b0;
        #1;
        chk("R4 launch wins over retire", 64'(occupancy), 64);
        chk("R4 relaunched warp issues", 64'(issue_valid), 1);
        @(negedge clk);
        launch_valid = 1'b0;
        #1;
        chk("R4 launch of resident warp", 64'(occupancy), 64);

        // R7: saturation of the stall counter
        ready_in = '0;
        repeat (300) @(negedge clk);
        #1;
        chk("R7 stall saturates", 64'(stall_count), 255);
        @(negedge clk);
        #1;
        chk("R7 stall held at max", 64'(stall_count), 255);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule